// File: doc/BRIEF.md
# Quad Latched Driver Controller

This block is the synchronous control core of a four-channel high-voltage switch driver. Data bits pass through a two-stage path. A transparent input latch captures them while the active-low chip-select and enable inputs are both low. An output register then takes the latched bits on each falling edge of output-enable. Each channel drives two controls: a high-side source control (1 = source high, 0 = high impedance) and a low-side gate control.

External threshold comparators report a pass/fail result for each channel. While output-enable is high, and once a programmable blanking interval has elapsed, the block samples these results. A failing channel is forced safe, with both controls off. A sticky active-low fault flag records the failure. Taking output-enable low releases the lockout and clears the flag, and the next high phase checks the channels again.

Every asynchronous control input passes through a two-flop synchronizer, and the output-enable edge is detected after synchronization. The blanking count is a quasi-static configuration input and is changed only while output-enable is low.

Top module: `quad_drv_ctrl`

## Requirements
- R1: The input latch follows the data bits only while both cs_ni and ena_ni are low (as seen after synchronization); if either is high it holds its contents.
- R2: The output register loads the latched bits on the synchronized falling edge of oe_i, so outputs change three clock edges after oe_i falls; otherwise it holds.
- R3: A channel whose register bit is 1 and which is not failed drives hs_drive_o = 1 and ls_gate_o = 0; hs_drive_o and ls_gate_o are never both 1.
- R4: A channel whose register bit is 0 and which is not failed drives hs_drive_o = 0 (high impedance) and ls_gate_o = 1.
- R5: A channel whose pass_i bit is 0 (fail) when sampled during oe_i high is forced to hs_drive_o = 0 and ls_gate_o = 0; the other channels are unaffected.
- R6: fault_no goes low when at least one channel has failed while oe_i is high.
- R7: Once low, fault_no stays low and failed channels stay locked even if pass_i recovers, until oe_i goes low; while synchronized oe_i is low, fault_no is 1 and all fail latches are cleared.
- R8: A fault that persists is detected again on every new high phase of oe_i.
- R9: After synchronized oe_i rises, pass_i is ignored for blank_cycles_i clock cycles; with blank_cycles_i = 0 sampling starts at once, and a failure first shows at the outputs 3 + blank_cycles_i edges after oe_i rises.
- R10: After reset every hs_drive_o bit is 0, every ls_gate_o bit is 1 and fault_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| ena_ni | input | 1 | Latch enable, active low, asynchronous |
| oe_i | input | 1 | Output enable; falling edge loads outputs, high phase arms fault checks |
| data_i | input | NCH | Channel data bits |
| pass_i | input | NCH | Comparator result per channel, 1 = pass, 0 = fail |
| blank_cycles_i | input | BLANK_W | Cycles to ignore pass_i after oe_i rises |
| hs_drive_o | output | NCH | High-side control, 1 = source high, 0 = high impedance |
| ls_gate_o | output | NCH | Low-side gate control, 1 = on |
| fault_no | output | 1 | Sticky fault flag, active low |

## Verification
The assertions check several rules on every cycle. The latch holds while it is closed. The output register moves only on a detected falling edge. Fail latches are sticky during a high phase and cleared while it is low. No failure is recorded inside the blanking window. No channel ever turns both of its controls on. Only the bench's scenarios can show the rest. That covers the exact three-edge latency and the blanking delay, and whether a failure on one channel leaves its neighbours running. It also covers whether a recovered comparator leaves the flag low, and whether a persistent fault comes back on the next high phase. A behavioural model tracks all of these cycle by cycle.

// File: rtl/quad_drv_pkg.sv
package quad_drv_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam logic CS_IDLE  = 1'b1;
  localparam logic ENA_IDLE = 1'b1;
  localparam logic OE_IDLE  = 1'b0;
endpackage

// File: rtl/drv_sync.sv
module drv_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned N = quad_drv_pkg::SYNC_DEPTH;
  logic [W-1:0] st_q [N];

  for (genvar s = 0; s < N; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[N-1];
endmodule

// File: rtl/drv_latch_stage.sv
module drv_latch_stage #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           ena_ni,
  input  logic           oe_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] out_o
);
  logic [NCH-1:0] lat_q, out_q;
  logic oe_d_q, oe_fall, lat_open;

  assign lat_open = !cs_ni && !ena_ni;
  assign oe_fall  = oe_d_q && !oe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      out_q  <= '0;
      oe_d_q <= quad_drv_pkg::OE_IDLE;
    end else begin
      oe_d_q <= oe_i;
      if (lat_open) lat_q <= data_i;
      if (oe_fall)  out_q <= lat_q;
    end
  end

  assign out_o = out_q;

  a_r1_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || ena_ni) |=> $stable(lat_q));
  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_d_q && !oe_i) |=> $stable(out_q));
endmodule

// File: rtl/drv_fault_ctrl.sv
module drv_fault_ctrl #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned BLANK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               oe_i,
  input  logic [NCH-1:0]     pass_i,
  input  logic [BLANK_W-1:0] blank_i,
  output logic [NCH-1:0]     fail_o,
  output logic               fault_no
);
  logic [BLANK_W-1:0] cnt_q;
  logic [NCH-1:0]     fail_q;
  logic               armed;

  assign armed = oe_i && (cnt_q >= blank_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= '0;
    end else if (!oe_i) begin
      cnt_q  <= '0;
      fail_q <= '0;
    end else begin
      if (cnt_q < blank_i) cnt_q <= cnt_q + 1'b1;
      if (armed) fail_q <= fail_q | ~pass_i;
    end
  end

  assign fail_o   = fail_q;
  assign fault_no = !(oe_i && |fail_q);

  a_r7_clear_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (fail_q == '0));
  a_r7_sticky_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
  a_r9_blank_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && cnt_q < blank_i && fail_q == '0) |=> (fail_q == '0));
endmodule

// File: rtl/quad_drv_ctrl.sv
module quad_drv_ctrl #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned BLANK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               ena_ni,
  input  logic               oe_i,
  input  logic [NCH-1:0]     data_i,
  input  logic [NCH-1:0]     pass_i,
  input  logic [BLANK_W-1:0] blank_cycles_i,
  output logic [NCH-1:0]     hs_drive_o,
  output logic [NCH-1:0]     ls_gate_o,
  output logic               fault_no
);
  import quad_drv_pkg::*;
  localparam int unsigned CW = 3;

  logic [CW-1:0]  ctl_s;
  logic [NCH-1:0] data_s, pass_s, out_bits, fail_bits;

  drv_sync #(.W(CW), .RST_VAL({CS_IDLE, ENA_IDLE, OE_IDLE})) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({cs_ni, ena_ni, oe_i}), .q_o(ctl_s));
  drv_sync #(.W(NCH), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s));
  drv_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_sync_pass (
    .clk_i, .rst_ni, .d_i(pass_i), .q_o(pass_s));

  drv_latch_stage #(.NCH(NCH)) u_latch (
    .clk_i, .rst_ni,
    .cs_ni(ctl_s[2]), .ena_ni(ctl_s[1]), .oe_i(ctl_s[0]),
    .data_i(data_s), .out_o(out_bits));

  drv_fault_ctrl #(.NCH(NCH), .BLANK_W(BLANK_W)) u_fault (
    .clk_i, .rst_ni, .oe_i(ctl_s[0]), .pass_i(pass_s),
    .blank_i(blank_cycles_i), .fail_o(fail_bits), .fault_no(fault_no));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      if (fail_bits[c]) begin
        hs_drive_o[c] = 1'b0;
        ls_gate_o[c]  = 1'b0;
      end else begin
        hs_drive_o[c] = out_bits[c];
        ls_gate_o[c]  = !out_bits[c];
      end
    end

    a_r3_no_shoot_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_drive_o[c] && ls_gate_o[c]));
  end
endmodule

// File: tb/tb_quad_drv_ctrl.sv
module tb_quad_drv_ctrl;
  localparam int NCH = 4;
  localparam int BW  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ena_n = 1'b1, oe = 1'b0;
  logic [NCH-1:0] data = '0, pass = '1;
  logic [BW-1:0] blank = '0;
  logic [NCH-1:0] hs, ls;
  logic fault_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_drv_ctrl #(.NCH(NCH), .BLANK_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ena_ni(ena_n), .oe_i(oe),
    .data_i(data), .pass_i(pass), .blank_cycles_i(blank),
    .hs_drive_o(hs), .ls_gate_o(ls), .fault_no(fault_n));

  // behavioural reference: input history, index 0 = newest sample
  typedef struct packed {logic cs_n; logic ena_n; logic oe; logic [NCH-1:0] d; logic [NCH-1:0] p;} smp_t;
  smp_t hist[$];
  logic [NCH-1:0] m_lat, m_out, m_fail;
  int m_cnt;
  logic [NCH-1:0] e_hs, e_ls;
  logic e_fault_n;

  function automatic smp_t idle_smp();
    return '{cs_n:1'b1, ena_n:1'b1, oe:1'b0, d:'0, p:'1};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {idle_smp(), idle_smp(), idle_smp()};
      m_lat = '0; m_out = '0; m_fail = '0; m_cnt = 0;
    end else begin
      smp_t a, b;
      logic [NCH-1:0] old_lat;
      a = hist[1]; b = hist[2];
      old_lat = m_lat;
      if (!a.cs_n && !a.ena_n) m_lat = a.d;
      if (b.oe && !a.oe) m_out = old_lat;
      if (!a.oe) begin
        m_fail = '0; m_cnt = 0;
      end else begin
        if (m_cnt >= int'(blank)) m_fail = m_fail | ~a.p;
        if (m_cnt < int'(blank)) m_cnt++;
      end
      hist.push_front('{cs_n:cs_n, ena_n:ena_n, oe:oe, d:data, p:pass});
      void'(hist.pop_back());
    end
    for (int i = 0; i < NCH; i++) begin
      e_hs[i] = m_fail[i] ? 1'b0 : m_out[i];
      e_ls[i] = m_fail[i] ? 1'b0 : !m_out[i];
    end
    e_fault_n = !(hist[1].oe && |m_fail);
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R3/R5 hs vs model", 8'(hs), 8'(e_hs));
    check("R4/R5 ls vs model", 8'(ls), 8'(e_ls));
    check("R6/R7 fault vs model", 8'(fault_n), 8'(e_fault_n));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [NCH-1:0] d);
    cs_n = 0; ena_n = 0; data = d; step(4);
    cs_n = 1; ena_n = 1; step(3);
    oe = 1; step(4);
    oe = 0; step(5);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    check("R10 reset hs", 8'(hs), 8'h0);
    check("R10 reset ls", 8'(ls), 8'hF);
    check("R10 reset fault", 8'(fault_n), 8'h1);
    rst_n = 1; step(2);

    // R2 latency: oe falls, outputs move on the third edge
    cs_n = 0; ena_n = 0; data = 4'b1010; step(4);
    cs_n = 1; ena_n = 1; oe = 1; step(4);
    oe = 0; step(2);
    check("R2 no change before third edge", 8'(hs), 8'h0);
    step(1);
    check("R2/R3 hs after load", 8'(hs), 8'hA);
    check("R4 ls after load", 8'(ls), 8'h5);

    // R1 latch closed when either select is high
    cs_n = 1; ena_n = 0; data = 4'b0101; step(4);
    cs_n = 0; ena_n = 1; data = 4'b0110; step(4);
    cs_n = 1; ena_n = 1;
    check("R2 hold without oe edge", 8'(hs), 8'hA);
    oe = 1; step(4); oe = 0; step(5);
    check("R1 latch held", 8'(hs), 8'hA);

    load(4'b0011);
    check("R3 second pattern hs", 8'(hs), 8'h3);
    check("R4 second pattern ls", 8'(ls), 8'hC);

    // R5/R6/R9 blanked fault on channel 1
    load(4'b1111);
    blank = 8'd5; pass = 4'b1101; oe = 1; step(6);
    check("R9 blanked fault ignored", 8'(fault_n), 8'h1);
    step(4);
    check("R6 fault flagged", 8'(fault_n), 8'h0);
    check("R5 failed channel hs off", 8'(hs), 8'hD);
    check("R5 failed channel ls off", 8'(ls), 8'h0);
    pass = 4'b1111; step(5);
    check("R7 fault sticky", 8'(fault_n), 8'h0);
    check("R7 lockout sticky", 8'(hs), 8'hD);
    oe = 0; step(3);
    check("R7 fault cleared by oe low", 8'(fault_n), 8'h1);
    check("R7 channel restored", 8'(hs), 8'hF);
    step(3);

    // R8/R9 persistent fault with no blanking
    blank = 8'd0; pass = 4'b1011; oe = 1; step(4);
    check("R9 immediate sample", 8'(fault_n), 8'h0);
    check("R5 channel 2 locked", 8'(hs), 8'hB);
    oe = 0; step(4);
    check("R7 cleared", 8'(fault_n), 8'h1);
    oe = 1; step(4);
    check("R8 re-detected", 8'(fault_n), 8'h0);
    oe = 0; pass = 4'b1111; step(5);
    check("R7 final clear", 8'(fault_n), 8'h1);
    finish_run();
  end
endmodule